// File: doc/BRIEF.md
# Configuration Stream Framing Monitor

This block watches the bytes that pass over a configuration data bus and marks the borders of the bitstream inside them. Any bytes ahead of the bitstream proper, such as a file header, are skipped while the block looks for the synchronisation sequence. Once that sequence completes, the block counts every following payload byte. It signals the end of the stream when the terminating word has been seen the required number of times back to back.

Each byte arrives with a valid strobe. The bus carries bytes in the target's bit order, which is the mirror image of the stored order, so a parameter makes the block flip each byte before it compares. A synchronous clear returns the block to its idle search state. The block does not decode configuration packets and does not check the CRC.

Top module: `cfg_frame_monitor`

## Requirements
- R1: After reset, and in the cycle after a clear, `sync_found_o`, `end_found_o` and `error_o` are 0 and `payload_cnt_o` is 0.
- R2: With `REVERSE_BITS`=1, each bus byte is mirrored (bus bit i is stored bit 7-i) and then matched against the stored sequence FF FF FF FF AA 99 55 66. `sync_found_o` is high for exactly the one cycle after the clock edge that accepts the eighth byte. An AA sent without mirroring does not match.
- R3: Bytes ahead of the sync sequence cause no pulse and no count. A run of more than four FF bytes followed by AA 99 55 66 still matches. Three FF bytes followed by AA 99 55 66 do not match.
- R4: `payload_cnt_o` reads 0 in the cycle of the sync pulse. After that it rises by one for every accepted byte up to and including the last byte of the end sequence, and then holds its value.
- R5: `end_found_o` is high for exactly the one cycle after the edge that accepts the last byte of the fourth consecutive stored word 20 00 00 00.
- R6: A byte that breaks a run of end words sets the repeat count back to zero. The broken bytes count as ordinary payload. If the breaking byte is 20, it starts a new first word.
- R7: A completed sync sequence while a frame is open sets `error_o` and restarts `payload_cnt_o` at 0.
- R8: An end sequence that completes while no frame is open still pulses `end_found_o` and sets `error_o`.
- R9: `error_o` stays high until `clear_i`. A clear drops it and returns the block to the sync search.
- R10: A cycle with `valid_i` low neither advances the matchers nor changes the counter.
- R11: `payload_cnt_o` saturates at its maximum value, 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous return to idle search; clears the error |
| valid_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Bus byte, in the target's bit order |
| sync_found_o | output | 1 | One-cycle pulse when the sync sequence completes |
| end_found_o | output | 1 | One-cycle pulse when the end sequence completes |
| payload_cnt_o | output | CNT_W | Bytes accepted since the last sync, saturating |
| error_o | output | 1 | Sticky framing error |

## Verification
Every result is registered once. The pulses, the counter and the error flag therefore change on the clock edge that accepts the deciding byte, and they are read in the following cycle. The bench drives each byte on a falling edge and samples on the next falling edge, so each check sees exactly the effect of the byte just sent. Pulse width is checked by sending one more byte and confirming that the pulse has dropped. The effect of a byte with the strobe low is checked on the next accepted byte.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int BYTE_W       = 8;
  localparam int SYNC_LEN     = 8;
  localparam int SYNC_PRE_LEN = 4;  // leading all-ones bytes
  localparam logic [8*SYNC_LEN-1:0] SYNC_SEQ = 64'hFFFF_FFFF_AA99_5566;
  localparam int END_WORD_LEN = 4;
  localparam logic [8*END_WORD_LEN-1:0] END_WORD = 32'h2000_0000;

  function automatic logic [BYTE_W-1:0] sync_byte(input int k);
    return SYNC_SEQ[8*SYNC_LEN-1-8*k -: 8];
  endfunction

  function automatic logic [BYTE_W-1:0] end_byte(input int k);
    return END_WORD[8*END_WORD_LEN-1-8*k -: 8];
  endfunction
endpackage

// File: rtl/cfm_bit_order.sv
module cfm_bit_order #(
  parameter bit REVERSE = 1'b1
) (
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  if (REVERSE) begin : g_rev
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign byte_o[i] = byte_i[7-i];
    end
  end else begin : g_pass
    assign byte_o = byte_i;
  end
endmodule

// File: rtl/cfm_sync_det.sv
module cfm_sync_det
  import cfm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              hit_o
);
  localparam int IDX_W = $clog2(SYNC_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SYNC_LEN - 1);
  localparam logic [IDX_W-1:0] PRE  = IDX_W'(SYNC_PRE_LEN);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic match;

  always_comb begin
    match = (byte_i == sync_byte(int'(idx_q)));
    hit_o = valid_i && match && (idx_q == LAST);
    idx_d = idx_q;
    if (valid_i) begin
      if (match)                idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
      else if (byte_i == 8'hFF) idx_d = (idx_q == PRE) ? idx_q : IDX_W'(1);  // extra preamble byte holds
      else                      idx_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (clear_i) idx_q <= '0;
    else              idx_q <= idx_d;
  end
endmodule

// File: rtl/cfm_end_det.sv
module cfm_end_det
  import cfm_pkg::*;
#(
  parameter int REPEATS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              hit_o
);
  localparam int POS_W = $clog2(END_WORD_LEN);
  localparam int REP_W = (REPEATS > 1) ? $clog2(REPEATS) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(END_WORD_LEN - 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEATS - 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic match, word_done;

  // Lead byte appears nowhere else in the word, so a mismatch falls back to 0 or 1.
  always_comb begin
    match     = (byte_i == end_byte(int'(pos_q)));
    word_done = match && (pos_q == POS_LAST);
    hit_o     = valid_i && word_done && (rep_q == REP_LAST);
    pos_d     = pos_q;
    rep_d     = rep_q;
    if (valid_i) begin
      if (match) begin
        pos_d = word_done ? '0 : pos_q + 1'b1;
        if (word_done) rep_d = (rep_q == REP_LAST) ? '0 : rep_q + 1'b1;
      end else begin
        rep_d = '0;
        pos_d = (byte_i == end_byte(0)) ? POS_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      rep_q <= '0;
    end else if (clear_i) begin
      pos_q <= '0;
      rep_q <= '0;
    end else begin
      pos_q <= pos_d;
      rep_q <= rep_d;
    end
  end
endmodule

// File: rtl/cfg_frame_monitor.sv
module cfg_frame_monitor
  import cfm_pkg::*;
#(
  parameter int CNT_W        = 24,
  parameter bit REVERSE_BITS = 1'b1,
  parameter int END_REPEATS  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             valid_i,
  input  logic [7:0]       byte_i,
  output logic             sync_found_o,
  output logic             end_found_o,
  output logic [CNT_W-1:0] payload_cnt_o,
  output logic             error_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [7:0] norm_byte;
  logic sync_hit, end_hit;
  logic in_frame_q;
  logic sync_q, end_q, err_q;
  logic [CNT_W-1:0] cnt_q;

  cfm_bit_order #(.REVERSE(REVERSE_BITS)) i_bit_order (
    .byte_i (byte_i),
    .byte_o (norm_byte)
  );

  cfm_sync_det i_sync_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .valid_i (valid_i),
    .byte_i  (norm_byte),
    .hit_o   (sync_hit)
  );

  cfm_end_det #(.REPEATS(END_REPEATS)) i_end_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .valid_i (valid_i),
    .byte_i  (norm_byte),
    .hit_o   (end_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      sync_q     <= 1'b0;
      end_q      <= 1'b0;
      err_q      <= 1'b0;
      cnt_q      <= '0;
    end else if (clear_i) begin
      in_frame_q <= 1'b0;
      sync_q     <= 1'b0;
      end_q      <= 1'b0;
      err_q      <= 1'b0;
      cnt_q      <= '0;
    end else begin
      sync_q <= sync_hit;
      end_q  <= end_hit;
      if (sync_hit) begin
        cnt_q      <= '0;
        in_frame_q <= 1'b1;
        if (in_frame_q) err_q <= 1'b1;  // restart without end
      end else if (valid_i && in_frame_q) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (end_hit) in_frame_q <= 1'b0;
      end
      if (end_hit && !in_frame_q) err_q <= 1'b1;  // end without sync
    end
  end

  assign sync_found_o  = sync_q;
  assign end_found_o   = end_q;
  assign payload_cnt_o = cnt_q;
  assign error_o       = err_q;
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             valid_i,
  input logic             sync_found_o,
  input logic             end_found_o,
  input logic [CNT_W-1:0] payload_cnt_o,
  input logic             error_o
);
  p_sync_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_found_o |=> !sync_found_o);

  p_end_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_found_o |=> !end_found_o);

  p_cnt_zero_at_sync_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_found_o |-> payload_cnt_o == '0);

  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (payload_cnt_o != $past(payload_cnt_o)) |->
      (payload_cnt_o == '0 || payload_cnt_o == CNT_W'($past(payload_cnt_o) + 1'b1)));

  p_idle_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clear_i) |=> ($stable(payload_cnt_o) && !sync_found_o && !end_found_o));

  p_error_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !clear_i) |=> error_o);

  p_clear_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!error_o && !sync_found_o && !end_found_o && payload_cnt_o == '0));
endmodule

bind cfg_frame_monitor cfm_checker #(.CNT_W(CNT_W)) i_cfm_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clear_i       (clear_i),
  .valid_i       (valid_i),
  .sync_found_o  (sync_found_o),
  .end_found_o   (end_found_o),
  .payload_cnt_o (payload_cnt_o),
  .error_o       (error_o)
);

// File: tb/test_cfg_frame_monitor.sv
module test_cfg_frame_monitor;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0;
  logic valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic sync_found_o, end_found_o, error_o;
  logic [CNT_W-1:0] payload_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_frame_monitor #(.CNT_W(CNT_W), .REVERSE_BITS(1'b1), .END_REPEATS(4)) i_cfg_frame_monitor (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .clear_i       (clear_i),
    .valid_i       (valid_i),
    .byte_i        (byte_i),
    .sync_found_o  (sync_found_o),
    .end_found_o   (end_found_o),
    .payload_cnt_o (payload_cnt_o),
    .error_o       (error_o)
  );

  function automatic logic [7:0] mirror(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Send a stored-order byte; returns one cycle later with the result visible.
  task automatic push(input logic [7:0] stored, input bit v = 1'b1, input bit raw = 1'b0);
    byte_i  = raw ? stored : mirror(stored);
    valid_i = v;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic push_sync_head();  // first 7 sync bytes
    for (int i = 0; i < 4; i++) push(8'hFF);
    push(8'hAA); push(8'h99); push(8'h55);
  endtask

  task automatic push_sync();
    push_sync_head();
    push(8'h66);
  endtask

  task automatic push_end_word();
    push(8'h20); push(8'h00); push(8'h00); push(8'h00);
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    chk("R1 clear cnt", int'(payload_cnt_o), 0);
    chk("R1 clear err", int'(error_o), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset sync", int'(sync_found_o), 0);
    chk("R1 reset end", int'(end_found_o), 0);
    chk("R1 reset cnt", int'(payload_cnt_o), 0);
    chk("R1 reset err", int'(error_o), 0);
  endtask

  task automatic t_basic_frame();
    push(8'h12); push(8'h34); push(8'hFF); push(8'h00);
    chk("R3 header no sync", int'(sync_found_o), 0);
    chk("R3 header no count", int'(payload_cnt_o), 0);
    push_sync_head();
    chk("R2 no early sync", int'(sync_found_o), 0);
    push(8'h66);
    chk("R2 sync pulse", int'(sync_found_o), 1);
    chk("R4 cnt zero at sync", int'(payload_cnt_o), 0);
    push(8'h01);
    chk("R2 sync one cycle", int'(sync_found_o), 0);
    for (int i = 0; i < 9; i++) push(8'(i + 2));
    chk("R4 payload count", int'(payload_cnt_o), 10);
    for (int i = 0; i < 3; i++) push_end_word();
    push(8'h20); push(8'h00); push(8'h00);
    chk("R5 no early end", int'(end_found_o), 0);
    push(8'h00);
    chk("R5 end pulse", int'(end_found_o), 1);
    chk("R4 count incl end", int'(payload_cnt_o), 26);
    push(8'h77);
    chk("R5 end one cycle", int'(end_found_o), 0);
    chk("R4 count holds", int'(payload_cnt_o), 26);
    chk("R8 no error", int'(error_o), 0);
  endtask

  task automatic t_preamble();
    for (int i = 0; i < 7; i++) push(8'hFF);
    push(8'hAA); push(8'h99); push(8'h55); push(8'h66);
    chk("R3 long preamble sync", int'(sync_found_o), 1);
    do_clear();
    for (int i = 0; i < 3; i++) push(8'hFF);
    push(8'hAA); push(8'h99); push(8'h55); push(8'h66);
    chk("R3 short preamble no sync", int'(sync_found_o), 0);
    for (int i = 0; i < 4; i++) push(8'hFF);
    push(8'hAA, 1'b1, 1'b1);  // unmirrored: wrong bit order
    push(8'h99); push(8'h55); push(8'h66);
    chk("R2 bit order matters", int'(sync_found_o), 0);
    do_clear();
  endtask

  task automatic t_end_break();
    push_sync();
    push_end_word(); push_end_word();
    push(8'h20); push(8'h00); push(8'h00); push(8'h55);
    for (int i = 0; i < 3; i++) push_end_word();
    chk("R6 break restarts repeats", int'(end_found_o), 0);
    push_end_word();
    chk("R6 end after fresh four", int'(end_found_o), 1);
    chk("R6 broken bytes are payload", int'(payload_cnt_o), 28);
    push_sync();
    chk("R7 sync after end ok", int'(error_o), 0);
    push(8'h20); push(8'h00);
    push_end_word();  // lead 20 starts new first word
    for (int i = 0; i < 2; i++) push_end_word();
    chk("R6 overlap not yet end", int'(end_found_o), 0);
    push_end_word();
    chk("R6 overlap end", int'(end_found_o), 1);
    chk("R6 overlap count", int'(payload_cnt_o), 18);
    do_clear();
  endtask

  task automatic t_gaps();
    push_sync_head();
    push(8'h66, 1'b0);
    chk("R10 invalid byte no sync", int'(sync_found_o), 0);
    push(8'h66);
    chk("R10 sync after gap", int'(sync_found_o), 1);
    push(8'h11); push(8'h11, 1'b0); push(8'h11, 1'b0); push(8'h11);
    chk("R10 gaps not counted", int'(payload_cnt_o), 2);
    do_clear();
  endtask

  task automatic t_restart();
    push_sync();
    push(8'h01); push(8'h02); push(8'h03);
    chk("R7 count before restart", int'(payload_cnt_o), 3);
    push_sync();
    chk("R7 restart error", int'(error_o), 1);
    chk("R7 restart cnt zero", int'(payload_cnt_o), 0);
    push(8'h04);
    chk("R9 error sticky", int'(error_o), 1);
    chk("R7 counting resumes", int'(payload_cnt_o), 1);
    do_clear();
    chk("R9 clear drops error", int'(error_o), 0);
  endtask

  task automatic t_orphan_end();
    for (int i = 0; i < 4; i++) push_end_word();
    chk("R8 orphan end pulse", int'(end_found_o), 1);
    chk("R8 orphan end error", int'(error_o), 1);
    chk("R8 no count outside frame", int'(payload_cnt_o), 0);
    do_clear();
  endtask

  task automatic t_saturate();
    push_sync();
    for (int i = 0; i < 40; i++) push(8'h11);
    chk("R11 saturation", int'(payload_cnt_o), 31);
    do_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_frame();
    do_clear();
    t_preamble();
    t_end_break();
    t_gaps();
    t_restart();
    t_orphan_end();
    t_saturate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule